// File: doc/BRIEF.md
# Stack and Block Multi-Register Transfer Sequencer

This block runs the multi-register memory transfers of a compact 16-bit-encoded processor core. It covers four operations: pushing registers onto a descending stack, popping them back, and storing or loading a group of registers at a base address that then advances. One start strobe carries a low-register bit list and an extra-slot bit. For a push, the extra slot is the link register. For a pop, it is the program counter. The strobe also carries either the stack pointer value or the index of a base register. The sequencer then moves one 32-bit word per accepted memory handshake through a plain request/response port. It reads or writes its own small register file as the words pass.

Every transfer is laid out in ascending register order on a word-aligned address that advances by four. A push lowers the stack pointer by the transfer size before it stores anything. A pop reads from the current pointer. When the transfer ends, the block pulses a done strobe and presents the new base or stack value. For the block forms, it also writes the advanced base back into the register file. A load that names its own base register keeps the loaded word instead of the advanced base. The register file also has one write port and one read port so that it can be loaded and inspected while the sequencer is idle.

Top module: `stk_xfer_seq`

## Requirements
- R1: The number of word accesses equals the count of set bits in the 8-bit list, plus one when the extra bit is set on a push (op 0) or a pop (op 1); the extra bit is ignored for store-multiple (op 2) and load-multiple (op 3).
- R2: A push (op 0) computes a new pointer of sp − 4·n, stores from that value with bits [1:0] cleared, and reports sp − 4·n on new_base_o.
- R3: A pop (op 1) reads from sp with bits [1:0] cleared and reports sp + 4·n on new_base_o.
- R4: Registers are moved lowest index first, and each accepted access is 4 above the previous one.
- R5: The extra slot is transferred last. A push stores the link register (file index 8); a pop loads the program counter (file index 9) with bit 0 forced to 0.
- R6: Store-multiple and load-multiple take the base from register base_idx_i (bits [1:0] cleared for addressing). At the end they write base + 4·n to that register and report the same value.
- R7: When a load-multiple list contains its base register, the loaded word stays in that register, no writeback occurs, and new_base_o reports the loaded word.
- R8: An empty transfer makes no memory request, leaves every register unchanged, reports the unmodified base or sp, and still pulses done.
- R9: done_o is high for exactly one cycle, in the cycle after the cycle in which the last response is accepted. For an empty transfer it is high in the cycle after the start.
- R10: A start strobe while busy_o is high is ignored.
- R11: While a request is waiting for its response, the address, write enable and write data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start strobe, taken only when idle |
| op_i | input | 2 | 0 push, 1 pop, 2 store-multiple, 3 load-multiple |
| rlist_i | input | 8 | Low-register list, bit i selects register i |
| xtra_i | input | 1 | Extra slot: link on push, program counter on pop |
| base_idx_i | input | 3 | Base register index for the block forms |
| sp_i | input | 32 | Stack pointer value for push and pop |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| new_base_o | output | 32 | Final base or stack value, valid with done_o |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Word address |
| mem_wdata_o | output | 32 | Write data |
| mem_rsp_i | input | 1 | Response; the access completes in a cycle with req and rsp both high |
| mem_rdata_i | input | 32 | Read data, valid with the response |
| rf_we_i | input | 1 | Register file write, honoured while idle |
| rf_waddr_i | input | 4 | Register file write index (0..9) |
| rf_wdata_i | input | 32 | Register file write data |
| rf_raddr_i | input | 4 | Register file read index |
| rf_rdata_o | output | 32 | Register file read data |

## Verification
The bench sweeps all 256 lists, both extra-bit values and all four operations. It runs these with unaligned base and stack values and with a responder that sometimes stalls. This exposes designs that pre-decrement from an unaligned pointer, that count the extra slot for the block forms, or that move the link or program counter out of last place. It also catches a pop that leaves bit 0 of the loaded program counter set. A load-multiple whose list covers its base register shows whether writeback wrongly overwrites the loaded word. Empty lists catch designs that issue a stray access or hang without done. A start strobe injected mid-transfer reveals a sequencer that restarts. Off-by-one done timing shows up as a pulse that comes early, comes late or lasts two cycles.

// File: rtl/stk_xfer_pkg.sv
package stk_xfer_pkg;
  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_STM  = 2'd2,
    OP_LDM  = 2'd3
  } xfer_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_FIN  = 2'd2
  } xfer_st_e;
endpackage

// File: rtl/stk_xfer_plan.sv
module stk_xfer_plan
  import stk_xfer_pkg::*;
#(
  parameter int NLOW = 8,
  parameter int DW   = 32,
  parameter int CW   = $clog2(NLOW + 2)
) (
  input  xfer_op_e        op_i,
  input  logic [NLOW-1:0] rlist_i,
  input  logic            xtra_i,
  input  logic [DW-1:0]   base_i,
  output logic [NLOW:0]   mask_o,
  output logic [CW-1:0]   cnt_o,
  output logic [DW-1:0]   first_addr_o,
  output logic [DW-1:0]   end_base_o
);
  logic          use_x;
  logic [DW-1:0] span;
  logic [DW-1:0] low_base;

  assign use_x  = (op_i == OP_PUSH) || (op_i == OP_POP);
  assign mask_o = {xtra_i & use_x, rlist_i};

  always_comb begin
    cnt_o = '0;
    for (int i = 0; i <= NLOW; i++) cnt_o = cnt_o + CW'(mask_o[i]);
  end

  assign span     = DW'(cnt_o) << 2;
  assign low_base = base_i - span;

  always_comb begin
    if (op_i == OP_PUSH) begin
      end_base_o   = low_base;
      first_addr_o = {low_base[DW-1:2], 2'b00};
    end else begin
      end_base_o   = base_i + span;
      first_addr_o = {base_i[DW-1:2], 2'b00};
    end
  end
endmodule

// File: rtl/stk_xfer_pick.sv
module stk_xfer_pick #(
  parameter int W  = 9,
  parameter int IW = $clog2(W)
) (
  input  logic [W-1:0]  mask_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o,
  output logic          last_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o  = |mask_i;
  assign last_o = any_o && ((mask_i & (mask_i - W'(1))) == '0);
endmodule

// File: rtl/stk_xfer_rf.sv
module stk_xfer_rf #(
  parameter int NREG = 10,
  parameter int DW   = 32,
  parameter int RIW  = $clog2(NREG)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           we_i,
  input  logic [RIW-1:0] waddr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic [RIW-1:0] ra_a_i,
  output logic [DW-1:0]  rd_a_o,
  input  logic [RIW-1:0] ra_b_i,
  output logic [DW-1:0]  rd_b_o,
  input  logic [RIW-1:0] ra_c_i,
  output logic [DW-1:0]  rd_c_o
);
  logic [DW-1:0] regs_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               regs_q[g] <= '0;
      else if (we_i && (waddr_i == RIW'(g)))     regs_q[g] <= wdata_i;
    end
  end

  function automatic logic [DW-1:0] rd(input logic [RIW-1:0] a);
    logic [DW-1:0] v;
    v = '0;
    for (int i = 0; i < NREG; i++) begin
      if (a == RIW'(i)) v = regs_q[i];
    end
    return v;
  endfunction

  assign rd_a_o = rd(ra_a_i);
  assign rd_b_o = rd(ra_b_i);
  assign rd_c_o = rd(ra_c_i);
endmodule

// File: rtl/stk_xfer_seq.sv
module stk_xfer_seq
  import stk_xfer_pkg::*;
#(
  parameter int NLOW = 8,
  parameter int DW   = 32
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  input  logic [1:0]                op_i,
  input  logic [NLOW-1:0]           rlist_i,
  input  logic                      xtra_i,
  input  logic [$clog2(NLOW)-1:0]   base_idx_i,
  input  logic [DW-1:0]             sp_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic [DW-1:0]             new_base_o,
  output logic                      mem_req_o,
  output logic                      mem_we_o,
  output logic [DW-1:0]             mem_addr_o,
  output logic [DW-1:0]             mem_wdata_o,
  input  logic                      mem_rsp_i,
  input  logic [DW-1:0]             mem_rdata_i,
  input  logic                      rf_we_i,
  input  logic [$clog2(NLOW+2)-1:0] rf_waddr_i,
  input  logic [DW-1:0]             rf_wdata_i,
  input  logic [$clog2(NLOW+2)-1:0] rf_raddr_i,
  output logic [DW-1:0]             rf_rdata_o
);
  localparam int NREG = NLOW + 2;
  localparam int RIW  = $clog2(NREG);
  localparam int BIW  = $clog2(NLOW);
  localparam int PIW  = $clog2(NLOW + 1);
  localparam int CW   = $clog2(NLOW + 2);
  localparam logic [RIW-1:0] LINK_IDX = RIW'(NLOW);
  localparam logic [RIW-1:0] PC_IDX   = RIW'(NLOW + 1);

  xfer_st_e        st_q, st_d;
  xfer_op_e        op_q, op_in;
  logic [NLOW:0]   mask_q, mask_d;
  logic [DW-1:0]   addr_q, addr_d;
  logic [DW-1:0]   nb_q, nb_d;
  logic [BIW-1:0]  bidx_q, bidx_d;
  logic            wb_q, wb_d;

  logic [NLOW:0]   plan_mask;
  logic [CW-1:0]   plan_cnt;
  logic [DW-1:0]   plan_first, plan_end, plan_base;

  logic [PIW-1:0]  pick_idx;
  logic            pick_any, pick_last;
  logic [RIW-1:0]  cur_reg;
  logic            is_load, accept;

  logic            rf_we;
  logic [RIW-1:0]  rf_wa;
  logic [DW-1:0]   rf_wd;
  logic [DW-1:0]   rf_rd_store, rf_rd_base;

  assign op_in = xfer_op_e'(op_i);

  stk_xfer_rf #(.NREG(NREG), .DW(DW), .RIW(RIW)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (rf_we),
    .waddr_i(rf_wa),
    .wdata_i(rf_wd),
    .ra_a_i (cur_reg),
    .rd_a_o (rf_rd_store),
    .ra_b_i (RIW'(base_idx_i)),
    .rd_b_o (rf_rd_base),
    .ra_c_i (rf_raddr_i),
    .rd_c_o (rf_rdata_o)
  );

  assign plan_base = ((op_in == OP_PUSH) || (op_in == OP_POP)) ? sp_i : rf_rd_base;

  stk_xfer_plan #(.NLOW(NLOW), .DW(DW), .CW(CW)) u_plan (
    .op_i        (op_in),
    .rlist_i     (rlist_i),
    .xtra_i      (xtra_i),
    .base_i      (plan_base),
    .mask_o      (plan_mask),
    .cnt_o       (plan_cnt),
    .first_addr_o(plan_first),
    .end_base_o  (plan_end)
  );

  stk_xfer_pick #(.W(NLOW + 1), .IW(PIW)) u_pick (
    .mask_i(mask_q),
    .idx_o (pick_idx),
    .any_o (pick_any),
    .last_o(pick_last)
  );

  // extra slot maps to link on push, program counter on pop
  assign cur_reg = (pick_idx == PIW'(NLOW)) ? ((op_q == OP_POP) ? PC_IDX : LINK_IDX)
                                            : RIW'(pick_idx);
  assign is_load = (op_q == OP_POP) || (op_q == OP_LDM);

  assign busy_o      = (st_q != ST_IDLE);
  assign done_o      = (st_q == ST_FIN);
  assign new_base_o  = nb_q;
  assign mem_req_o   = (st_q == ST_XFER) && pick_any;
  assign mem_we_o    = mem_req_o && !is_load;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = mem_we_o ? rf_rd_store : '0;
  assign accept      = mem_req_o && mem_rsp_i;

  always_comb begin
    rf_we = 1'b0;
    rf_wa = rf_waddr_i;
    rf_wd = rf_wdata_i;
    unique case (st_q)
      ST_IDLE: rf_we = rf_we_i;
      ST_XFER: begin
        if (accept && is_load) begin
          rf_we = 1'b1;
          rf_wa = cur_reg;
          rf_wd = (cur_reg == PC_IDX) ? {mem_rdata_i[DW-1:1], 1'b0} : mem_rdata_i;
        end
      end
      ST_FIN: begin
        if (wb_q) begin
          rf_we = 1'b1;
          rf_wa = RIW'(bidx_q);
          rf_wd = nb_q;
        end
      end
      default: rf_we = 1'b0;
    endcase
  end

  always_comb begin
    st_d   = st_q;
    mask_d = mask_q;
    addr_d = addr_q;
    nb_d   = nb_q;
    bidx_d = bidx_q;
    wb_d   = wb_q;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          bidx_d = base_idx_i;
          if (plan_cnt == '0) begin
            st_d   = ST_FIN;
            mask_d = '0;
            nb_d   = plan_base;
            wb_d   = 1'b0;
          end else begin
            st_d   = ST_XFER;
            mask_d = plan_mask;
            addr_d = plan_first;
            nb_d   = plan_end;
            wb_d   = (op_in == OP_STM) || (op_in == OP_LDM);
          end
        end
      end
      ST_XFER: begin
        if (accept) begin
          mask_d[pick_idx] = 1'b0;
          addr_d           = addr_q + DW'(4);
          if ((op_q == OP_LDM) && (cur_reg == RIW'(bidx_q))) begin
            wb_d = 1'b0;
            nb_d = mem_rdata_i;
          end
          if (pick_last) st_d = ST_FIN;
        end
      end
      ST_FIN:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      op_q   <= OP_PUSH;
      mask_q <= '0;
      addr_q <= '0;
      nb_q   <= '0;
      bidx_q <= '0;
      wb_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      mask_q <= mask_d;
      addr_q <= addr_d;
      nb_q   <= nb_d;
      bidx_q <= bidx_d;
      wb_q   <= wb_d;
      if ((st_q == ST_IDLE) && start_i) op_q <= op_in;
    end
  end
endmodule

// File: rtl/stk_xfer_chk.sv
module stk_xfer_chk #(
  parameter int NLOW = 8,
  parameter int DW   = 32,
  parameter int RIW  = $clog2(NLOW + 2)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           busy_o,
  input logic           done_o,
  input logic           mem_req_o,
  input logic           mem_we_o,
  input logic [DW-1:0]  mem_addr_o,
  input logic [DW-1:0]  mem_wdata_o,
  input logic           mem_rsp_i,
  input logic           rf_we,
  input logic [RIW-1:0] rf_wa,
  input logic [DW-1:0]  rf_wd
);
  // R4
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && $past(mem_req_o && mem_rsp_i)) |-> (mem_addr_o == $past(mem_addr_o) + DW'(4)));

  // R2
  addr_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  // R11
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_rsp_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                   && $stable(mem_wdata_o)));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  done_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!mem_req_o && busy_o));

  // R5
  pc_even_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_we && busy_o && (rf_wa == RIW'(NLOW + 1))) |-> (rf_wd[0] == 1'b0));
endmodule

bind stk_xfer_seq stk_xfer_chk #(.NLOW(NLOW), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .mem_req_o  (mem_req_o),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_wdata_o(mem_wdata_o),
  .mem_rsp_i  (mem_rsp_i),
  .rf_we      (rf_we),
  .rf_wa      (rf_wa),
  .rf_wd      (rf_wd)
);

// File: tb/stk_xfer_seq_bench.sv
module stk_xfer_seq_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [1:0]  op_i = '0;
  logic [7:0]  rlist_i = '0;
  logic        xtra_i = 1'b0;
  logic [2:0]  base_idx_i = '0;
  logic [31:0] sp_i = '0;
  logic        busy_o, done_o, mem_req_o, mem_we_o, mem_rsp_i;
  logic [31:0] new_base_o, mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic        rf_we_i = 1'b0;
  logic [3:0]  rf_waddr_i = '0, rf_raddr_i = '0;
  logic [31:0] rf_wdata_i = '0, rf_rdata_o;

  logic        stall_en = 1'b0;
  logic [1:0]  cyc = '0;
  int          checks = 0, errors = 0;
  bit          finished = 0;

  always #4 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 2'd1;

  function automatic logic [31:0] rd_fn(input logic [31:0] a);
    return ~a ^ 32'h0000_5A3C;
  endfunction

  function automatic logic [31:0] pre(input int r);
    return 32'h4000_1000 + 32'(r << 8) + 32'(r & 3);
  endfunction

  assign mem_rsp_i   = mem_req_o && !(stall_en && (cyc == 2'b01));
  assign mem_rdata_i = rd_fn(mem_addr_o);

  stk_xfer_seq u_stk_xfer_seq (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run(input int op, input logic [7:0] rl, input bit x, input int bidx,
                     input logic [31:0] sp, input bit inj);
    int          exp_reg [10];
    int          n;
    logic [31:0] base, first, nb, addr;
    logic [31:0] exp_rf [10];
    int          k, t, last_t;
    bit          injected, got_done;

    for (int r = 0; r < 10; r++) begin
      @(posedge clk_i); #1;
      rf_we_i = 1'b1; rf_waddr_i = 4'(r); rf_wdata_i = pre(r);
    end
    @(posedge clk_i); #1;
    rf_we_i = 1'b0;

    n = 0;
    for (int i = 0; i < 8; i++) if (rl[i]) begin exp_reg[n] = i; n++; end
    if (x && op < 2) begin exp_reg[n] = 8; n++; end
    base = (op < 2) ? sp : pre(bidx);
    if (op == 0) begin nb = base - 32'(4 * n); first = {nb[31:2], 2'b00}; end
    else begin nb = base + 32'(4 * n); first = {base[31:2], 2'b00}; end
    if (n == 0) nb = base;
    for (int r = 0; r < 10; r++) exp_rf[r] = pre(r);
    if (op == 1 || op == 3) begin
      for (int j = 0; j < n; j++) begin
        addr = first + 32'(4 * j);
        if (exp_reg[j] == 8) exp_rf[9] = rd_fn(addr) & 32'hFFFF_FFFE;
        else exp_rf[exp_reg[j]] = rd_fn(addr);
      end
    end
    if (op >= 2 && n > 0) begin
      if (op == 3 && rl[bidx]) nb = exp_rf[bidx];
      else exp_rf[bidx] = nb;
    end

    start_i = 1'b1; op_i = 2'(op); rlist_i = rl; xtra_i = x;
    base_idx_i = 3'(bidx); sp_i = sp;
    @(posedge clk_i); #1;
    start_i = 1'b0;
    k = 0; t = 0; last_t = -1; injected = 0; got_done = 0;
    while (!got_done && t < 80) begin
      @(negedge clk_i);
      t++;
      if (injected) start_i = 1'b0;
      if (mem_req_o && mem_rsp_i) begin
        addr = first + 32'(4 * k);
        chk("R1 access count", 32'(k < n), 32'd1);
        chk("R2 R3 R4 access address", mem_addr_o, addr);
        chk("R1 R6 access direction", 32'(mem_we_o), 32'(op == 0 || op == 2));
        if ((op == 0 || op == 2) && k < n)
          chk("R5 R6 store data", mem_wdata_o, pre(exp_reg[k]));
        k++;
        last_t = t;
        if (inj && k == 1 && !injected) begin
          start_i = 1'b1; op_i = 2'(op ^ 1); rlist_i = ~rl; injected = 1;
        end
      end
      if (done_o) begin
        got_done = 1;
        chk("R1 R8 total accesses", 32'(k), 32'(n));
        chk("R2 R3 R6 R7 R8 new base", new_base_o, nb);
        if (n > 0) chk("R9 done timing", 32'(t - last_t), 32'd1);
        else chk("R8 R9 empty done timing", 32'(t), 32'd1);
      end
    end
    start_i = 1'b0;
    if (!got_done) chk("R9 done seen", 32'd0, 32'd1);
    @(negedge clk_i);
    chk("R9 done single cycle", 32'(done_o), 32'd0);
    for (int r = 0; r < 10; r++) begin
      rf_raddr_i = 4'(r);
      #1;
      chk("R5 R6 R7 R8 R10 register file", rf_rdata_o, exp_rf[r]);
    end
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R9 watchdog act=0 exp=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R8 reset done", 32'(done_o), 32'd0);
    chk("R8 reset req", 32'(mem_req_o), 32'd0);
    chk("R10 reset busy", 32'(busy_o), 32'd0);
    rst_ni = 1'b1;
    for (int op = 0; op < 4; op++) begin
      for (int rl = 0; rl < 256; rl++) begin
        for (int x = 0; x < 2; x++) begin
          stall_en = (rl[0] ^ x[0]) == 1'b1;
          run(op, 8'(rl), x[0], (rl + op) % 8,
              32'h2000_0100 + 32'(rl << 2) + 32'({x[0], op[0]}), rl[2] == 1'b1);
        end
      end
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule